// File: doc/BRIEF.md
# Warp Predicate and Condition-Flag Unit

This block sits beside the issue stage of a SIMD core that runs a warp of 32 lanes in lock-step. It keeps two small pieces of state for every lane. The first is a 4-bit condition code that holds sign, carry, zero and overflow. The second is a one-bit predicate. A compare operation subtracts two signed operands in each lane and writes the flags. In the same cycle it latches one selected signed relation into the predicate.

Every issued operation carries an optional guard. The guard tests the lane's predicate either as it is or inverted. The guard result is ANDed with the warp active mask to give a per-lane execute enable. That enable gates the register-writeback strobe and also the memory-request strobe. A lane that is inactive, or that fails its guard, therefore never produces memory traffic. The same enable also decides which lanes a compare may update.

Outputs are registered, so the strobes appear one clock after issue. The guard reads the predicate as it stood before the issuing edge. A compare is therefore visible to the very next operation.

Top module: `lane_guard_unit`

## Requirements
- R1: While reset is asserted (active low, synchronous to the clock), and on the first cycle after it is released, every flag, predicate, execute-enable, writeback and memory-request output reads zero.
- R2: A compare computes a minus b per lane. The lane's nibble in `flags_out` (lane i at bits 4i+3..4i) is laid out as bit 3 sign (MSB of the difference), bit 2 carry (set when a >= b unsigned, i.e. no borrow), bit 1 zero (a == b) and bit 0 overflow (signed overflow of the subtraction).
- R3: A compare latches into the lane predicate the signed relation chosen by `cmp_cond`: 0 equal, 1 not equal, 2 less, 3 less-or-equal, 4 greater, 5 greater-or-equal. Codes 6 and 7 latch 0.
- R4: A compare updates the flags and predicate only in lanes whose execute enable is set. All other lanes, and every lane on a non-compare operation, keep their previous values.
- R5: For an unguarded operation, the execute enable equals the active mask.
- R6: For a guarded operation, lane i is enabled when its active bit is set and its predicate XOR `guard_negate` is 1.
- R7: `wb_strobe` is the execute enable for ALU (op 2) and load (op 3) operations. It is zero otherwise.
- R8: `mem_req` is the execute enable for load (op 3) and store (op 4) operations. It is zero otherwise, so a suppressed lane never raises a memory request.
- R9: The strobes appear on the clock after issue. The guard uses the predicate value from before the issuing edge, so a compare is seen by the operation issued directly after it.
- R10: No-op (op 0) and the unused codes 5 to 7 raise no execute enable, no strobe and change no state. A compare (op 1) raises the execute enable with no writeback and no memory strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_op | input | 3 | Operation kind: 0 no-op, 1 compare, 2 ALU, 3 load, 4 store |
| guard_on | input | 1 | Operation is guarded by the lane predicate |
| guard_negate | input | 1 | Guard tests the inverted predicate |
| cmp_cond | input | 3 | Relation latched into the predicate by a compare |
| active_mask | input | 32 | Warp active-lane mask |
| opnd_a | input | 1024 | Per-lane first operand, lane i at bits 32i+31..32i |
| opnd_b | input | 1024 | Per-lane second operand, same packing |
| flags_out | output | 128 | Per-lane condition code |
| pred_out | output | 32 | Per-lane predicate |
| exec_en | output | 32 | Registered per-lane execute enable |
| wb_strobe | output | 32 | Per-lane register-writeback strobe |
| mem_req | output | 32 | Per-lane memory-request strobe |

## Verification
Some properties hold on every cycle, and the checker tests them all the time. Writeback and memory strobes never appear outside the execute enable. The enable never exceeds the previous cycle's active mask. State only moves after a compare. A set zero flag always comes with carry set and sign and overflow clear. No-ops and unused codes leave every strobe low.

The exact flag values, the relation picked by each condition code, the effect of the inverted guard and the back-to-back compare-then-guard timing need known operands. Only the bench's scenarios, compared each clock against its behavioural model, can show these.

// File: rtl/lgu_pkg.sv
package lgu_pkg;

    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_CMP   = 3'd1,
        OP_ALU   = 3'd2,
        OP_LOAD  = 3'd3,
        OP_STORE = 3'd4
    } op_e;

    localparam logic [2:0] REL_EQ = 3'd0;
    localparam logic [2:0] REL_NE = 3'd1;
    localparam logic [2:0] REL_LT = 3'd2;
    localparam logic [2:0] REL_LE = 3'd3;
    localparam logic [2:0] REL_GT = 3'd4;
    localparam logic [2:0] REL_GE = 3'd5;

    typedef struct packed {
        logic sgn;
        logic cry;
        logic zro;
        logic ovf;
    } ccode_t;

    localparam int CC_W = $bits(ccode_t);

endpackage

// File: rtl/lane_flag_calc.sv
module lane_flag_calc
    import lgu_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic [2:0]    sel,
    output ccode_t        cc,
    output logic          rel_hit
);
    logic [DW:0]   wide;
    logic [DW-1:0] diff;
    logic          lt_s;

    always_comb begin
        wide   = {1'b0, a} - {1'b0, b};
        diff   = wide[DW-1:0];
        cc.sgn = diff[DW-1];
        cc.cry = ~wide[DW];
        cc.zro = (diff == '0);
        cc.ovf = (a[DW-1] ^ b[DW-1]) & (diff[DW-1] ^ a[DW-1]);
        lt_s   = cc.sgn ^ cc.ovf;
        unique case (sel)
            REL_EQ:  rel_hit = cc.zro;
            REL_NE:  rel_hit = ~cc.zro;
            REL_LT:  rel_hit = lt_s;
            REL_LE:  rel_hit = lt_s | cc.zro;
            REL_GT:  rel_hit = ~(lt_s | cc.zro);
            REL_GE:  rel_hit = ~lt_s;
            default: rel_hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/lane_guard_eval.sv
module lane_guard_eval #(
    parameter int LANES = 32
) (
    input  logic [LANES-1:0] active,
    input  logic [LANES-1:0] pred,
    input  logic             guard_on,
    input  logic             guard_negate,
    output logic [LANES-1:0] enable
);
    logic [LANES-1:0] pass;

    always_comb begin
        if (guard_on) pass = pred ^ {LANES{guard_negate}};
        else          pass = '1;
        enable = active & pass;
    end

endmodule

// File: rtl/lane_guard_unit.sv
module lane_guard_unit
    import lgu_pkg::*;
#(
    parameter int LANES = 32,
    parameter int DW    = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [2:0]             issue_op,
    input  logic                   guard_on,
    input  logic                   guard_negate,
    input  logic [2:0]             cmp_cond,
    input  logic [LANES-1:0]       active_mask,
    input  logic [LANES*DW-1:0]    opnd_a,
    input  logic [LANES*DW-1:0]    opnd_b,
    output logic [LANES*CC_W-1:0]  flags_out,
    output logic [LANES-1:0]       pred_out,
    output logic [LANES-1:0]       exec_en,
    output logic [LANES-1:0]       wb_strobe,
    output logic [LANES-1:0]       mem_req
);
    op_e              op;
    logic             do_any, do_cmp, do_wb, do_mem;
    logic [LANES-1:0] lane_en;
    logic [LANES-1:0] pred_q, pred_d, rel_new;
    ccode_t           flags_q [LANES];
    ccode_t           flags_d [LANES];
    ccode_t           cc_new  [LANES];
    logic [LANES-1:0] en_q, wb_q, mem_q;

    assign op = op_e'(issue_op);

    // Operation decode
    always_comb begin
        do_any = 1'b0;
        do_cmp = 1'b0;
        do_wb  = 1'b0;
        do_mem = 1'b0;
        unique case (op)
            OP_CMP:   begin do_any = 1'b1; do_cmp = 1'b1; end
            OP_ALU:   begin do_any = 1'b1; do_wb  = 1'b1; end
            OP_LOAD:  begin do_any = 1'b1; do_wb  = 1'b1; do_mem = 1'b1; end
            OP_STORE: begin do_any = 1'b1; do_mem = 1'b1; end
            default:  ;
        endcase
    end

    lane_guard_eval #(.LANES(LANES)) u_guard (
        .active       (active_mask),
        .pred         (pred_q),
        .guard_on     (guard_on),
        .guard_negate (guard_negate),
        .enable       (lane_en)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        lane_flag_calc #(.DW(DW)) u_calc (
            .a       (opnd_a[i*DW +: DW]),
            .b       (opnd_b[i*DW +: DW]),
            .sel     (cmp_cond),
            .cc      (cc_new[i]),
            .rel_hit (rel_new[i])
        );
        assign flags_out[i*CC_W +: CC_W] = flags_q[i];
    end

    // Next-state for per-lane condition state
    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            if (do_cmp && lane_en[i]) begin
                flags_d[i] = cc_new[i];
                pred_d[i]  = rel_new[i];
            end else begin
                flags_d[i] = flags_q[i];
                pred_d[i]  = pred_q[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LANES; i++) flags_q[i] <= '0;
            pred_q <= '0;
            en_q   <= '0;
            wb_q   <= '0;
            mem_q  <= '0;
        end else begin
            for (int i = 0; i < LANES; i++) flags_q[i] <= flags_d[i];
            pred_q <= pred_d;
            en_q   <= do_any ? lane_en : '0;
            wb_q   <= do_wb  ? lane_en : '0;
            mem_q  <= do_mem ? lane_en : '0;
        end
    end

    assign pred_out  = pred_q;
    assign exec_en   = en_q;
    assign wb_strobe = wb_q;
    assign mem_req   = mem_q;

endmodule

// File: rtl/lgu_checker.sv
module lgu_checker #(
    parameter int LANES = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic [2:0]         issue_op,
    input logic [LANES-1:0]   active_mask,
    input logic [LANES*4-1:0] flags_out,
    input logic [LANES-1:0]   pred_out,
    input logic [LANES-1:0]   exec_en,
    input logic [LANES-1:0]   wb_strobe,
    input logic [LANES-1:0]   mem_req
);
    AST_WB_INSIDE_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_strobe & ~exec_en) == '0); // R7

    AST_MEM_INSIDE_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req & ~exec_en) == '0); // R8

    AST_MEM_ONLY_LDST: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(issue_op) != 3'd3 && $past(issue_op) != 3'd4) |-> (mem_req == '0)); // R8

    AST_EN_INSIDE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en & ~$past(active_mask)) == '0); // R5

    AST_PRED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(issue_op) != 3'd1) |-> $stable(pred_out)); // R4

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(issue_op) != 3'd1) |-> $stable(flags_out)); // R4

    AST_NOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(issue_op) == 3'd0 || $past(issue_op) > 3'd4)
        |-> (exec_en == '0 && wb_strobe == '0 && mem_req == '0)); // R10

    for (genvar i = 0; i < LANES; i++) begin : g_cc
        AST_ZERO_CONSISTENT: assert property (@(posedge clk) disable iff (!rst_n)
            flags_out[i*4+1] |-> (flags_out[i*4+2] && !flags_out[i*4+3] && !flags_out[i*4])); // R2
    end

endmodule

bind lane_guard_unit lgu_checker #(.LANES(LANES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_op    (issue_op),
    .active_mask (active_mask),
    .flags_out   (flags_out),
    .pred_out    (pred_out),
    .exec_en     (exec_en),
    .wb_strobe   (wb_strobe),
    .mem_req     (mem_req)
);

// File: tb/sim_lane_guard_unit.sv
module sim_lane_guard_unit;
    localparam int CLK_PERIOD = 10;
    localparam int LANES = 32;
    localparam int DW    = 32;

    logic                  clk = 1'b0;
    logic                  rst_n;
    logic [2:0]            issue_op;
    logic                  guard_on, guard_negate;
    logic [2:0]            cmp_cond;
    logic [LANES-1:0]      active_mask;
    logic [LANES*DW-1:0]   opnd_a, opnd_b;
    logic [LANES*4-1:0]    flags_out;
    logic [LANES-1:0]      pred_out, exec_en, wb_strobe, mem_req;

    int checks = 0;
    int errors = 0;

    // reference state
    logic [3:0]       m_flags [LANES];
    logic [LANES-1:0] m_pred;
    logic [LANES-1:0] x_en, x_wb, x_mem;

    always #(CLK_PERIOD/2) clk = ~clk;

    lane_guard_unit #(.LANES(LANES), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .issue_op(issue_op), .guard_on(guard_on),
        .guard_negate(guard_negate), .cmp_cond(cmp_cond), .active_mask(active_mask),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .flags_out(flags_out), .pred_out(pred_out),
        .exec_en(exec_en), .wb_strobe(wb_strobe), .mem_req(mem_req)
    );

    task automatic check(input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [3:0] ref_flags(input logic [DW-1:0] a, input logic [DW-1:0] b);
        longint sa = longint'($signed(a));
        longint sb = longint'($signed(b));
        longint d  = sa - sb;
        logic [DW-1:0] diff = a - b;
        logic s = diff[DW-1];
        logic c = (a >= b);
        logic z = (a == b);
        logic v = (d > 64'sd2147483647) || (d < -64'sd2147483648);
        return {s, c, z, v};
    endfunction

    function automatic logic ref_rel(input logic [DW-1:0] a, input logic [DW-1:0] b,
                                     input logic [2:0] sel);
        int sa = $signed(a);
        int sb = $signed(b);
        case (sel)
            3'd0: return sa == sb;
            3'd1: return sa != sb;
            3'd2: return sa <  sb;
            3'd3: return sa <= sb;
            3'd4: return sa >  sb;
            3'd5: return sa >= sb;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [127:0] pack_flags();
        logic [127:0] r = '0;
        for (int i = 0; i < LANES; i++) r[i*4 +: 4] = m_flags[i];
        return r;
    endfunction

    task automatic compare_all(input string ctx);
        check({ctx, " R2"}, "flags", flags_out, pack_flags());
        check({ctx, " R3"}, "pred",  pred_out,  m_pred);
        check({ctx, " R5"}, "exec_en", exec_en, x_en);
        check({ctx, " R7"}, "wb_strobe", wb_strobe, x_wb);
        check({ctx, " R8"}, "mem_req", mem_req, x_mem);
    endtask

    // Issue one operation at a falling edge and compare after the next rising edge.
    task automatic step(input string ctx, input logic [2:0] op, input logic g,
                        input logic n, input logic [2:0] cond, input logic [LANES-1:0] mask);
        logic [LANES-1:0] en;
        issue_op = op; guard_on = g; guard_negate = n; cmp_cond = cond; active_mask = mask;
        for (int i = 0; i < LANES; i++)
            en[i] = mask[i] && (!g || (m_pred[i] != n));
        x_en  = (op >= 3'd1 && op <= 3'd4) ? en : '0;
        x_wb  = (op == 3'd2 || op == 3'd3) ? en : '0;
        x_mem = (op == 3'd3 || op == 3'd4) ? en : '0;
        if (op == 3'd1) begin
            for (int i = 0; i < LANES; i++) begin
                if (en[i]) begin
                    m_flags[i] = ref_flags(opnd_a[i*DW +: DW], opnd_b[i*DW +: DW]);
                    m_pred[i]  = ref_rel(opnd_a[i*DW +: DW], opnd_b[i*DW +: DW], cond);
                end
            end
        end
        @(posedge clk);
        @(negedge clk);
        compare_all(ctx);
    endtask

    task automatic fill_random(input int eq_every);
        for (int i = 0; i < LANES; i++) begin
            opnd_a[i*DW +: DW] = $urandom();
            opnd_b[i*DW +: DW] = (eq_every > 0 && (i % eq_every) == 0) ? opnd_a[i*DW +: DW] : $urandom();
            if (i % 5 == 1) opnd_b[i*DW +: DW] = opnd_a[i*DW +: DW] + 32'd1;
        end
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; issue_op = 3'd0; guard_on = 1'b0; guard_negate = 1'b0;
        cmp_cond = 3'd0; active_mask = '0; opnd_a = '0; opnd_b = '0;
        for (int i = 0; i < LANES; i++) m_flags[i] = 4'h0;
        m_pred = '0; x_en = '0; x_wb = '0; x_mem = '0;
        repeat (3) @(negedge clk);
        compare_all("R1 in-reset");
        rst_n = 1'b1;
        @(negedge clk);
        compare_all("R1 after-reset");

        // every relation code, unguarded, all lanes active
        for (int s = 0; s < 8; s++) begin
            fill_random(3);
            step("R3 relation sweep", 3'd1, 1'b0, 1'b0, 3'(s), '1);
        end

        // corner operands: equal, overflow both ways, zero/one, all-ones
        fill_random(0);
        opnd_a[0*DW +: DW] = 32'h1234_5678; opnd_b[0*DW +: DW] = 32'h1234_5678;
        opnd_a[1*DW +: DW] = 32'h7FFF_FFFF; opnd_b[1*DW +: DW] = 32'h8000_0000;
        opnd_a[2*DW +: DW] = 32'h8000_0000; opnd_b[2*DW +: DW] = 32'h0000_0001;
        opnd_a[3*DW +: DW] = 32'h0000_0000; opnd_b[3*DW +: DW] = 32'h0000_0001;
        opnd_a[4*DW +: DW] = 32'hFFFF_FFFF; opnd_b[4*DW +: DW] = 32'h0000_0000;
        opnd_a[5*DW +: DW] = 32'h0000_0000; opnd_b[5*DW +: DW] = 32'h0000_0000;
        step("R2 corner LT", 3'd1, 1'b0, 1'b0, 3'd2, '1);
        check("R2", "lane1 overflow flags", flags_out[4 +: 4], 4'b1001);
        check("R2", "lane0 equal flags", flags_out[0 +: 4], 4'b0110);
        step("R3 corner GE", 3'd1, 1'b0, 1'b0, 3'd5, '1);
        check("R3", "lane1 max>=min pred", pred_out[1], 1'b1);

        // partial active mask, then compare guarded by the predicate
        fill_random(4);
        step("R4 masked compare", 3'd1, 1'b0, 1'b0, 3'd4, 32'h0F0F_3C3C);
        fill_random(2);
        step("R4 guarded compare", 3'd1, 1'b1, 1'b0, 3'd1, '1);
        step("R4 neg guarded compare", 3'd1, 1'b1, 1'b1, 3'd3, 32'hFFFF_0000);

        // unguarded ALU / load / store under several masks
        step("R5 alu full", 3'd2, 1'b0, 1'b1, 3'd0, '1);
        step("R5 alu part", 3'd2, 1'b0, 1'b0, 3'd0, 32'hA5A5_0F0F);
        step("R5 load part", 3'd3, 1'b0, 1'b0, 3'd0, 32'h0000_FFFF);
        step("R5 store none", 3'd4, 1'b0, 1'b0, 3'd0, '0);

        // guarded memory traffic, plain and inverted
        step("R6 guarded load", 3'd3, 1'b1, 1'b0, 3'd0, '1);
        step("R6 negated load", 3'd3, 1'b1, 1'b1, 3'd0, '1);
        step("R6 guarded store", 3'd4, 1'b1, 1'b0, 3'd0, 32'h3333_CCCC);
        step("R6 negated store", 3'd4, 1'b1, 1'b1, 3'd0, 32'hFF00_FF00);
        step("R6 guarded alu", 3'd2, 1'b1, 1'b1, 3'd0, 32'h5555_AAAA);

        // idle and unused codes
        for (int c = 5; c < 8; c++)
            step("R10 unused code", 3'(c), 1'b0, 1'b0, 3'd2, '1);
        step("R10 nop", 3'd0, 1'b1, 1'b0, 3'd0, '1);

        // compare immediately followed by a store guarded on it
        fill_random(3);
        step("R9 cmp", 3'd1, 1'b0, 1'b0, 3'd0, '1);
        step("R9 store on new pred", 3'd4, 1'b1, 1'b0, 3'd0, '1);
        fill_random(2);
        step("R9 cmp again", 3'd1, 1'b0, 1'b0, 3'd1, '1);
        step("R9 load on inverted pred", 3'd3, 1'b1, 1'b1, 3'd0, '1);

        // random mix
        for (int k = 0; k < 300; k++) begin
            if (k % 3 == 0) fill_random(int'($urandom_range(0, 4)));
            step("R9 random mix", 3'($urandom_range(0, 7)), 1'($urandom()), 1'($urandom()),
                 3'($urandom_range(0, 7)), LANES'($urandom()));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule